// File: doc/BRIEF.md
# Disk Controller Data Buffer

This block is the byte buffer between a host's data-register port and the byte stream on the disk side of a floppy-style disk controller. During the command phase it works as a plain one-byte holding register. The host paces each parameter byte with the ready and direction status bits, and the byte is passed on to the command decoder. During the execution phase it becomes a first-in first-out store of up to `DEPTH` bytes. It raises a service request when the stored count (read direction) or the free space (write direction) reaches a programmed threshold.

After reset the block stays in single-byte mode until a configure load enables buffering. Two faults end a transfer and latch an error flag. The first is an overrun, where the disk delivers a byte into a full buffer. The second is an underrun, where the disk needs a byte while the buffer is empty. After a read overrun the host can still drain the bytes already stored before the result phase is signalled. After a write underrun the block fills out the sector with zero bytes and then emits a CRC-16 computed over everything sent.

Top module: `fdc_data_fifo`

## Requirements
- R1: After reset: rqm=1, dio=0, srv_req=0, xfer_err=0, result_ready=0, and the buffer is in single-byte mode.
- R2: In the command phase a host write is presented on par_byte with par_valid=1 in the next cycle. rqm is 0 for that one cycle, and dio stays 0.
- R3: A cfg_load pulse sets buffered mode from cfg_buf_en and sets the threshold from cfg_thresh (1 to 15). A threshold value of 0 is treated as 1.
- R4: An exec_start pulse empties the buffer, so no byte stored before it can reach the host.
- R5: In the read execution phase dio=1. Disk bytes are stored in arrival order, rqm=1 while any byte is stored, and host reads return the bytes in order on host_rdata.
- R6: srv_req is 1 only in the execution phases. In read direction it is 1 when the stored count is at least the threshold. In write direction it is 1 when the free space is at least the threshold.
- R7: In the write execution phase dio=0 and rqm=1 while free space remains. Each dsk_strobe delivers the oldest byte on dsk_wdata, with dsk_wvalid=1 in the cycle after the strobe.
- R8: In single-byte mode the capacity is one byte and the threshold is one, so a second disk byte arriving before the first is read is an overrun.
- R9: On a read overrun xfer_err is set and the incoming byte is dropped. rqm stays 1 until all stored bytes are read, and result_ready rises only once the buffer is empty.
- R10: On a write underrun xfer_err is set and that strobe and all later strobes up to the sector length send 0x00. Host writes during padding are ignored (rqm=0).
- R11: After SECT_LEN sector bytes the next two strobes send a CRC-16 with polynomial 0x1021, preset 0xFFFF, MSB first, covering every sent sector byte including pads. The high byte goes first, and then result_ready=1.
- R12: xfer_err stays set until the next cmd_start.
- R13: A read that collects SECT_LEN bytes without overrun reaches result_ready once the host has drained the buffer, with xfer_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Oldest stored byte, valid while rqm=1 in read direction |
| cfg_load | input | 1 | Configure load pulse |
| cfg_buf_en | input | 1 | Enable buffered mode |
| cfg_thresh | input | THR_W | Service threshold |
| cmd_start | input | 1 | A new command begins |
| exec_start | input | 1 | Execution phase begins |
| exec_to_host | input | 1 | Direction of the execution phase, 1 = disk to host |
| par_valid | output | 1 | Command parameter byte present |
| par_byte | output | 8 | Command parameter byte |
| dsk_strobe | input | 1 | Disk-side byte slot |
| dsk_rdata | input | 8 | Byte from the disk (read direction) |
| dsk_wvalid | output | 1 | Byte toward the disk is valid |
| dsk_wdata | output | 8 | Byte toward the disk |
| rqm | output | 1 | Host may perform the next byte access |
| dio | output | 1 | 1 = data flows toward the host |
| srv_req | output | 1 | Service request at threshold |
| xfer_err | output | 1 | Overrun or underrun latched |
| result_ready | output | 1 | Result phase may start |

## Verification
The checker checks on every cycle that the fill level never exceeds the depth and that an execution start leaves the buffer empty. It also checks that the service request appears only in execution phases, that the direction bit is high whenever data moves toward the host, that the error flag holds until a command start, and that the result phase after a drain is entered only with an empty buffer. Only the bench scenarios can show byte ordering, the threshold crossings at particular fill levels, that a dropped overrun byte never reaches the host, that host writes during padding do not appear on the disk side, and that the two CRC bytes match the sector contents.

// File: rtl/fdc_fifo_pkg.sv
package fdc_fifo_pkg;

  typedef enum logic [2:0] {
    PH_CMD,    // command phase, single holding register
    PH_RD,     // execution, disk to host
    PH_WR,     // execution, host to disk
    PH_DRAIN,  // read stopped, host empties the buffer
    PH_PAD,    // write underrun, zero fill
    PH_CRC,    // two check bytes toward disk
    PH_RES     // result phase may start
  } phase_t;

  // One byte through a CRC-16, MSB first
  function automatic logic [15:0] crc16_byte(input logic [15:0] cur, input logic [7:0] b,
                                             input logic [15:0] poly);
    logic [15:0] r;
    r = cur;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ poly;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] fill
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: ;
      endcase
    end
  end

  assign head = mem[rd_ptr];

endmodule

// File: rtl/sector_crc.sv
module sector_crc
  import fdc_fifo_pkg::*;
#(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  always_ff @(posedge clk) begin
    if (rst || clear) crc <= INIT;
    else if (en)      crc <= crc16_byte(crc, din, POLY);
  end

endmodule

// File: rtl/fdc_data_fifo.sv
module fdc_data_fifo
  import fdc_fifo_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int SECT_LEN = 512,
  parameter int THR_W    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic [7:0]       host_wdata,
  input  logic             host_rd,
  output logic [7:0]       host_rdata,
  input  logic             cfg_load,
  input  logic             cfg_buf_en,
  input  logic [THR_W-1:0] cfg_thresh,
  input  logic             cmd_start,
  input  logic             exec_start,
  input  logic             exec_to_host,
  output logic             par_valid,
  output logic [7:0]       par_byte,
  input  logic             dsk_strobe,
  input  logic [7:0]       dsk_rdata,
  output logic             dsk_wvalid,
  output logic [7:0]       dsk_wdata,
  output logic             rqm,
  output logic             dio,
  output logic             srv_req,
  output logic             xfer_err,
  output logic             result_ready
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int SEC_W = $clog2(SECT_LEN + 1);

  phase_t           phase;
  logic             buf_en_q;
  logic [THR_W-1:0] thr_q;
  logic             err_q;
  logic             par_valid_q;
  logic [7:0]       par_byte_q;
  logic [SEC_W-1:0] sec_cnt;
  logic             crc_lo_sel;
  logic             wv_q;
  logic [7:0]       wd_q;

  logic [CNT_W-1:0] fill, cap, thr_eff, free_sp;
  logic [7:0]       head, fifo_din, crc_din;
  logic [15:0]      crc;
  logic             flush, push, pop, room, have, sec_last, quiet, crc_en;

  assign flush    = cmd_start || exec_start;
  assign quiet    = !flush;
  assign cap      = buf_en_q ? CNT_W'(DEPTH) : CNT_W'(1);
  assign thr_eff  = buf_en_q ? CNT_W'(thr_q) : CNT_W'(1);
  assign room     = fill < cap;
  assign have     = fill != '0;
  assign free_sp  = cap - fill;
  assign sec_last = sec_cnt == SEC_W'(SECT_LEN - 1);

  assign push = quiet && room &&
                ((phase == PH_RD && dsk_strobe) || (phase == PH_WR && host_wr));
  assign pop  = quiet && have &&
                (((phase == PH_RD || phase == PH_DRAIN) && host_rd) ||
                 (phase == PH_WR && dsk_strobe));
  assign fifo_din = (phase == PH_RD) ? dsk_rdata : host_wdata;

  fifo_store #(.DEPTH(DEPTH), .W(8)) u_store (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .pop(pop),
    .din(fifo_din), .head(head), .fill(fill)
  );

  assign crc_en  = quiet && dsk_strobe && (phase == PH_WR || phase == PH_PAD);
  assign crc_din = (phase == PH_WR && have) ? head : 8'h00;

  sector_crc u_crc (
    .clk(clk), .rst(rst), .clear(exec_start), .en(crc_en), .din(crc_din), .crc(crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_CMD;
      buf_en_q    <= 1'b0;
      thr_q       <= THR_W'(1);
      err_q       <= 1'b0;
      par_valid_q <= 1'b0;
      par_byte_q  <= '0;
      sec_cnt     <= '0;
      crc_lo_sel  <= 1'b0;
      wv_q        <= 1'b0;
      wd_q        <= '0;
    end else begin
      par_valid_q <= 1'b0;
      wv_q        <= 1'b0;
      if (cfg_load) begin
        buf_en_q <= cfg_buf_en;
        thr_q    <= (cfg_thresh == '0) ? THR_W'(1) : cfg_thresh;
      end
      if (cmd_start) begin
        phase <= PH_CMD;
        err_q <= 1'b0;
      end else if (exec_start) begin
        phase      <= exec_to_host ? PH_RD : PH_WR;
        sec_cnt    <= '0;
        crc_lo_sel <= 1'b0;
      end else begin
        case (phase)
          PH_CMD: if (host_wr && !par_valid_q) begin
            par_valid_q <= 1'b1;
            par_byte_q  <= host_wdata;
          end
          PH_RD: if (dsk_strobe) begin
            if (!room) begin
              err_q <= 1'b1;
              phase <= PH_DRAIN;
            end else begin
              sec_cnt <= sec_cnt + 1'b1;
              if (sec_last) phase <= PH_DRAIN;
            end
          end
          PH_DRAIN: if (!have) phase <= PH_RES;
          PH_WR: if (dsk_strobe) begin
            wv_q    <= 1'b1;
            wd_q    <= have ? head : 8'h00;
            sec_cnt <= sec_cnt + 1'b1;
            if (!have) err_q <= 1'b1;
            if (sec_last)   phase <= PH_CRC;
            else if (!have) phase <= PH_PAD;
          end
          PH_PAD: if (dsk_strobe) begin
            wv_q    <= 1'b1;
            wd_q    <= 8'h00;
            sec_cnt <= sec_cnt + 1'b1;
            if (sec_last) phase <= PH_CRC;
          end
          PH_CRC: if (dsk_strobe) begin
            wv_q       <= 1'b1;
            wd_q       <= crc_lo_sel ? crc[7:0] : crc[15:8];
            crc_lo_sel <= 1'b1;
            if (crc_lo_sel) phase <= PH_RES;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rqm     = 1'b0;
    dio     = 1'b0;
    srv_req = 1'b0;
    case (phase)
      PH_CMD:   rqm = !par_valid_q;
      PH_RD: begin
        rqm     = have;
        dio     = 1'b1;
        srv_req = fill >= thr_eff;
      end
      PH_DRAIN: begin
        rqm = have;
        dio = 1'b1;
      end
      PH_WR: begin
        rqm     = room;
        srv_req = free_sp >= thr_eff;
      end
      PH_RES:   dio = 1'b1;
      default: ;
    endcase
  end

  assign host_rdata   = head;
  assign par_valid    = par_valid_q;
  assign par_byte     = par_byte_q;
  assign dsk_wvalid   = wv_q;
  assign dsk_wdata    = wd_q;
  assign xfer_err     = err_q;
  assign result_ready = phase == PH_RES;

endmodule

// File: rtl/fdc_data_fifo_chk.sv
module fdc_data_fifo_chk
  import fdc_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input phase_t           phase,
  input logic [CNT_W-1:0] fill,
  input logic             err,
  input logic             srv_req,
  input logic             dio,
  input logic             rqm,
  input logic             cmd_start,
  input logic             exec_start
);

  p_fill_bound_r5: assert property (@(posedge clk) disable iff (rst)
    fill <= CNT_W'(DEPTH));

  p_exec_flush_r4: assert property (@(posedge clk) disable iff (rst)
    exec_start |=> fill == '0);

  p_req_exec_only_r6: assert property (@(posedge clk) disable iff (rst)
    srv_req |-> (phase == PH_RD || phase == PH_WR));

  p_dio_to_host_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RD || phase == PH_DRAIN) |-> dio);

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    (err && !cmd_start) |=> err);

  p_result_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RES && $past(phase) == PH_DRAIN) |-> fill == '0);

  p_pad_no_host_r10: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PAD || phase == PH_CRC) |-> !rqm);

endmodule

bind fdc_data_fifo fdc_data_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .fill(fill), .err(err_q),
  .srv_req(srv_req), .dio(dio), .rqm(rqm),
  .cmd_start(cmd_start), .exec_start(exec_start)
);

// File: tb/tb_fdc_data_fifo.sv
module tb_fdc_data_fifo;

  localparam int DEPTH = 16;
  localparam int SECT  = 8;
  localparam int THR_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 0, host_rd = 0, cfg_load = 0, cfg_buf_en = 0;
  logic cmd_start = 0, exec_start = 0, exec_to_host = 0, dsk_strobe = 0;
  logic [7:0] host_wdata = '0, dsk_rdata = '0;
  logic [THR_W-1:0] cfg_thresh = '0;
  logic [7:0] host_rdata, par_byte, dsk_wdata;
  logic par_valid, dsk_wvalid, rqm, dio, srv_req, xfer_err, result_ready;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fdc_data_fifo #(.DEPTH(DEPTH), .SECT_LEN(SECT), .THR_W(THR_W)) dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .cfg_load(cfg_load),
    .cfg_buf_en(cfg_buf_en), .cfg_thresh(cfg_thresh), .cmd_start(cmd_start),
    .exec_start(exec_start), .exec_to_host(exec_to_host), .par_valid(par_valid),
    .par_byte(par_byte), .dsk_strobe(dsk_strobe), .dsk_rdata(dsk_rdata),
    .dsk_wvalid(dsk_wvalid), .dsk_wdata(dsk_wdata), .rqm(rqm), .dio(dio),
    .srv_req(srv_req), .xfer_err(xfer_err), .result_ready(result_ready)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic tick(); @(negedge clk); endtask
  task automatic pulse_cmd();
    @(negedge clk) cmd_start = 1; @(negedge clk) cmd_start = 0;
  endtask
  task automatic pulse_exec(input bit to_host);
    @(negedge clk) begin exec_start = 1; exec_to_host = to_host; end
    @(negedge clk) exec_start = 0;
  endtask
  task automatic do_cfg(input bit en, input int thr);
    @(negedge clk) begin cfg_load = 1; cfg_buf_en = en; cfg_thresh = THR_W'(thr); end
    @(negedge clk) cfg_load = 0;
  endtask
  task automatic hwrite(input logic [7:0] b);
    @(negedge clk) begin host_wr = 1; host_wdata = b; end
    @(negedge clk) host_wr = 0;
  endtask
  task automatic hread(output logic [7:0] b);
    @(negedge clk) begin b = host_rdata; host_rd = 1; end
    @(negedge clk) host_rd = 0;
  endtask
  task automatic din(input logic [7:0] b);
    @(negedge clk) begin dsk_strobe = 1; dsk_rdata = b; end
    @(negedge clk) dsk_strobe = 0;
  endtask
  task automatic dout(output logic [7:0] b, output logic v);
    @(negedge clk) dsk_strobe = 1;
    @(negedge clk) begin dsk_strobe = 0; v = dsk_wvalid; b = dsk_wdata; end
  endtask

  task automatic t_reset();
    chk("R1 rqm", rqm, 1);
    chk("R1 dio", dio, 0);
    chk("R1 srv_req", srv_req, 0);
    chk("R1 err", xfer_err, 0);
    chk("R1 result", result_ready, 0);
  endtask

  task automatic t_command();
    hwrite(8'hA5);
    chk("R2 par_valid", par_valid, 1);
    chk("R2 par_byte", par_byte, 8'hA5);
    chk("R2 rqm busy", rqm, 0);
    chk("R2 dio", dio, 0);
    tick();
    chk("R2 rqm back", rqm, 1);
    chk("R2 par_valid clear", par_valid, 0);
  endtask

  task automatic t_unbuf_read();
    logic [7:0] b;
    pulse_cmd();
    pulse_exec(1);
    din(8'h11);
    chk("R8 rqm", rqm, 1);
    chk("R5 dio", dio, 1);
    chk("R8 srv_req thr1", srv_req, 1);
    din(8'h22);
    chk("R8 overrun err", xfer_err, 1);
    chk("R9 rqm while data", rqm, 1);
    hread(b);
    chk("R9 kept byte", b, 8'h11);
    chk("R9 rqm empty", rqm, 0);
    chk("R9 no result yet", result_ready, 0);
    tick();
    chk("R9 result after drain", result_ready, 1);
    chk("R12 err held", xfer_err, 1);
  endtask

  task automatic t_cfg_flush();
    logic [7:0] b;
    pulse_cmd();
    chk("R12 err cleared", xfer_err, 0);
    do_cfg(1, 4);
    pulse_exec(1);
    for (int i = 0; i < 3; i++) din(8'hA1 + 8'(i));
    chk("R6 below thr", srv_req, 0);
    din(8'hA4);
    chk("R3 R6 at thr", srv_req, 1);
    pulse_exec(1);
    chk("R4 flushed rqm", rqm, 0);
    chk("R4 flushed srv", srv_req, 0);
    din(8'h77);
    hread(b);
    chk("R4 no stale byte", b, 8'h77);
  endtask

  task automatic t_buf_read();
    logic [7:0] b;
    pulse_cmd();
    pulse_exec(1);
    for (int i = 0; i < SECT; i++) din(8'h40 + 8'(i * 3));
    chk("R13 no err", xfer_err, 0);
    for (int i = 0; i < SECT; i++) begin
      hread(b);
      chk("R5 order", b, 8'h40 + 8'(i * 3));
    end
    tick();
    chk("R13 result", result_ready, 1);
    chk("R13 err clear", xfer_err, 0);
  endtask

  task automatic t_buf_write();
    logic [7:0] b;
    logic v;
    logic [15:0] c;
    pulse_cmd();
    pulse_exec(0);
    chk("R7 dio", dio, 0);
    chk("R7 rqm", rqm, 1);
    chk("R6 free srv", srv_req, 1);
    for (int i = 0; i < 13; i++) hwrite(8'h30 + 8'(i));
    chk("R6 free below thr", srv_req, 0);
    for (int i = 13; i < 16; i++) hwrite(8'h30 + 8'(i));
    chk("R7 full rqm", rqm, 0);
    c = 16'hFFFF;
    for (int i = 0; i < SECT; i++) begin
      dout(b, v);
      chk("R7 wvalid", v, 1);
      chk("R7 order", b, 8'h30 + 8'(i));
      c = ref_crc(c, 8'h30 + 8'(i));
    end
    dout(b, v);
    chk("R11 crc hi", b, c[15:8]);
    dout(b, v);
    chk("R11 crc lo", b, c[7:0]);
    chk("R11 result", result_ready, 1);
    chk("R11 no err", xfer_err, 0);
  endtask

  task automatic t_underrun();
    logic [7:0] b;
    logic v;
    logic [15:0] c;
    pulse_cmd();
    pulse_exec(0);
    c = 16'hFFFF;
    for (int i = 0; i < 3; i++) hwrite(8'hC1 + 8'(i));
    for (int i = 0; i < 3; i++) begin
      dout(b, v);
      chk("R7 data", b, 8'hC1 + 8'(i));
      c = ref_crc(c, 8'hC1 + 8'(i));
    end
    dout(b, v);
    chk("R10 pad valid", v, 1);
    chk("R10 pad zero", b, 0);
    chk("R10 err", xfer_err, 1);
    chk("R10 rqm off", rqm, 0);
    c = ref_crc(c, 8'h00);
    hwrite(8'h99);
    for (int i = 4; i < SECT; i++) begin
      dout(b, v);
      chk("R10 pad ignores host", b, 0);
      c = ref_crc(c, 8'h00);
    end
    dout(b, v);
    chk("R11 pad crc hi", b, c[15:8]);
    dout(b, v);
    chk("R11 pad crc lo", b, c[7:0]);
    chk("R11 pad result", result_ready, 1);
    chk("R12 err still", xfer_err, 1);
    pulse_cmd();
    chk("R12 cleared by cmd", xfer_err, 0);
  endtask

  task automatic t_thresh_edge();
    pulse_cmd();
    do_cfg(1, 15);
    pulse_exec(0);
    hwrite(8'h01);
    chk("R6 free 15 of 15", srv_req, 1);
    hwrite(8'h02);
    chk("R6 free 14 of 15", srv_req, 0);
    pulse_cmd();
    do_cfg(1, 0);
    pulse_exec(1);
    din(8'h5A);
    chk("R3 zero thr acts as 1", srv_req, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    tick();
    t_reset();
    t_command();
    t_unbuf_read();
    t_cfg_flush();
    t_buf_read();
    t_buf_write();
    t_underrun();
    t_thresh_edge();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule